// File: doc/BRIEF.md
# Edge and Center-Aligned PWM Timer

A 16-bit counter with one compare channel that generates a PWM reference waveform. In edge-aligned operation the counter either counts up from 0 to the period limit and wraps, or counts down from the period limit to 0 and reloads. The software direction input picks between the two. In center-aligned operation the counter climbs from 0 to the period limit and then descends back to 0, repeating without end. In that operation the hardware owns the direction, the software direction input is ignored, and the direction output reports which slope the counter is on.

The compare value and period limit take effect in the cycle they are presented. A sticky compare flag records matches between the counter and the compare value. In center-aligned operation the 2-bit mode field decides on which slopes the flag may set. Software clears the flag by pulsing a clear input.

Top module: `pwm_align_timer`

## Requirements
- R1: While `rst_n` is low, `count` is 0, `cmp_flag` is 0 and `pwm_ref` is 0. After release, the internal reset stays asserted for two more rising clock edges.
- R2: With `cmode`=00 and `dir_sel`=0, each enabled cycle increments `count`. When `count` is at or above `period`, it returns to 0 on the next cycle instead. `pwm_ref` is 1 exactly when `count` < `compare`.
- R3: With `cmode`=00 and `dir_sel`=1, each enabled cycle decrements `count`. When `count` is 0 or above `period`, it loads `period` on the next cycle instead. `pwm_ref` is 1 exactly when `count` <= `compare`, so a `compare` above `period` holds it at 1.
- R4: With `cmode` nonzero and `period` > 0, the counter rises by one per enabled cycle until it reaches `period`, then falls to 0, then rises again. `dir_now` reads 1 on the falling slope and 0 on the rising slope, and `dir_sel` has no effect on the count.
- R5: With `cmode` nonzero, `pwm_ref` is 1 when `count` < `compare` or when `compare` >= `period`. A `compare` of 0 therefore keeps it low when `period` > 0. All three nonzero modes give the same waveform.
- R6: A match (`count` == `compare` in an enabled cycle) sets `cmp_flag` one cycle later. In mode 00 every match counts. In mode 01 only matches while `dir_now`=1 count, in mode 10 only matches while `dir_now`=0, and in mode 11 matches on both slopes count.
- R7: `cmp_flag` stays set until a cycle with `flag_clr`=1 clears it. A match in the same cycle as a clear leaves the flag set.
- R8: With `enable`=0, `count` and the internal direction hold their values, `pwm_ref` is 0, and no match sets the flag.
- R9: With `cmode`=00, `dir_now` equals `dir_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Count enable |
| cmode | input | 2 | 00 edge-aligned, 01/10/11 center-aligned with flag on down/up/both slopes |
| dir_sel | input | 1 | Edge-aligned direction: 0 up, 1 down |
| period | input | 16 | Period limit |
| compare | input | 16 | Compare value |
| flag_clr | input | 1 | Clear pulse for the compare flag |
| pwm_ref | output | 1 | PWM reference output |
| cmp_flag | output | 1 | Sticky compare-match flag |
| dir_now | output | 1 | Current count direction, 1 = down |
| count | output | 16 | Counter value |

## Verification
`count` and the internal direction change one rising edge after the enabled cycle that computes them. `pwm_ref` and `dir_now` are combinational from the present count and inputs, so they are valid within the same cycle. `cmp_flag` rises or falls one edge after the cycle that holds the match or the clear. The bench drives inputs on the falling edge and pushes the expected values for that cycle into a queue. A monitor pops each entry one time unit later, still before the next rising edge, so each count, reference and flag value is compared in the cycle it is due.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  typedef enum logic [1:0] {
    CM_EDGE = 2'b00,
    CM_DN   = 2'b01,
    CM_UP   = 2'b10,
    CM_BOTH = 2'b11
  } cmode_e;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  cmode_e       mode,
  input  logic         dir_sel,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt_q,
  output logic         dir_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_d;
  logic         dir_d;
  logic         lim_zero;

  assign lim_zero = (limit == '0);

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (mode == CM_EDGE) begin
      dir_d = dir_sel;
      if (!dir_sel) cnt_d = (cnt_q >= limit) ? '0 : cnt_q + ONE;
      else          cnt_d = (cnt_q == '0 || cnt_q > limit) ? limit : cnt_q - ONE;
    end else if (!dir_q) begin
      if (cnt_q >= limit) begin
        dir_d = 1'b1;
        cnt_d = lim_zero ? '0 : limit - ONE;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      if (cnt_q == '0) begin
        dir_d = 1'b0;
        cnt_d = lim_zero ? '0 : ONE;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assert_edge_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == CM_EDGE && !dir_sel && cnt_q >= limit) |=> (cnt_q == '0));

  assert_down_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == CM_EDGE && dir_sel && cnt_q == '0) |=> (cnt_q == $past(limit)));

  assert_center_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode != CM_EDGE && !dir_q && cnt_q >= limit && !lim_zero) |=> dir_q);

  assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt_q) && $stable(dir_q)));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         en,
  input  logic         run,
  input  cmode_e       mode,
  input  logic         dir_sel,
  input  logic         dir_q,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] limit,
  input  logic [W-1:0] cmp,
  output logic         ref_o,
  output logic         dir_o,
  output logic         hit_o
);
  logic lvl;
  logic slope_ok;

  assign dir_o = (mode == CM_EDGE) ? dir_sel : dir_q;

  always_comb begin
    if (mode == CM_EDGE) lvl = dir_sel ? (cnt <= cmp) : (cnt < cmp);
    else                 lvl = (cnt < cmp) || (cmp >= limit);
  end

  always_comb begin
    unique case (mode)
      CM_DN:   slope_ok = dir_q;
      CM_UP:   slope_ok = !dir_q;
      default: slope_ok = 1'b1;
    endcase
  end

  assign ref_o = en && run && lvl;
  assign hit_o = en && run && slope_ok && (cnt == cmp);
endmodule

// File: rtl/pwm_flag.sv
module pwm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag_q);
endmodule

// File: rtl/pwm_align_timer.sv
module pwm_align_timer
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       cmode,
  input  logic             dir_sel,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] compare,
  input  logic             flag_clr,
  output logic             pwm_ref,
  output logic             cmp_flag,
  output logic             dir_now,
  output logic [CNT_W-1:0] count
);
  logic   rst_i;
  logic   dir_q;
  logic   hit;
  cmode_e mode;

  assign mode = cmode_e'(cmode);

  pwm_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i)
  );

  pwm_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i), .en(enable), .mode(mode), .dir_sel(dir_sel),
    .limit(period), .cnt_q(count), .dir_q(dir_q)
  );

  pwm_compare #(.W(CNT_W)) u_cmp (
    .en(enable), .run(rst_i), .mode(mode), .dir_sel(dir_sel), .dir_q(dir_q),
    .cnt(count), .limit(period), .cmp(compare),
    .ref_o(pwm_ref), .dir_o(dir_now), .hit_o(hit)
  );

  pwm_flag u_flag (
    .clk(clk), .rst_n(rst_i), .hit(hit), .clr(flag_clr), .flag_q(cmp_flag)
  );
endmodule

// File: tb/sim_pwm_align_timer.sv
module sim_pwm_align_timer;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  cmode = 2'b00;
  logic        dir_sel = 1'b0;
  logic [15:0] period = 16'd8;
  logic [15:0] compare = 16'd4;
  logic        flag_clr = 1'b0;
  logic        pwm_ref, cmp_flag, dir_now;
  logic [15:0] count;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] cnt;
    logic        rf;
    logic        fl;
    logic        dr;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [15:0] m_cnt = '0;
  logic        m_dir = 1'b0;
  logic        m_flag = 1'b0;

  pwm_align_timer u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cmode(cmode), .dir_sel(dir_sel),
    .period(period), .compare(compare), .flag_clr(flag_clr),
    .pwm_ref(pwm_ref), .cmp_flag(cmp_flag), .dir_now(dir_now), .count(count)
  );

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic check(string tag, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: apply inputs at the falling edge, push expected values, advance model.
  task automatic drive(input logic e, input logic [1:0] m, input logic ds,
                       input logic [15:0] p, input logic [15:0] c,
                       input logic cl, input string tag);
    exp_t it;
    logic cur_dir, lvl, hit, slope;
    @(negedge clk);
    enable = e; cmode = m; dir_sel = ds; period = p; compare = c; flag_clr = cl;
    cur_dir = (m == 2'b00) ? ds : m_dir;
    if (m == 2'b00) lvl = ds ? (m_cnt <= c) : (m_cnt < c);
    else            lvl = (m_cnt < c) || (c >= p);
    slope = (m == 2'b01) ? m_dir : (m == 2'b10) ? !m_dir : 1'b1;
    hit = e && slope && (m_cnt == c);
    it.cnt = m_cnt; it.rf = e && lvl; it.fl = m_flag; it.dr = cur_dir; it.tag = tag;
    q.push_back(it);
    if (hit)     m_flag = 1'b1;
    else if (cl) m_flag = 1'b0;
    if (e) begin
      if (m == 2'b00) begin
        m_dir = ds;
        if (!ds) m_cnt = (m_cnt >= p) ? 16'd0 : m_cnt + 16'd1;
        else     m_cnt = (m_cnt == 0 || m_cnt > p) ? p : m_cnt - 16'd1;
      end else if (!m_dir) begin
        if (m_cnt >= p) begin m_dir = 1'b1; m_cnt = (p == 0) ? 16'd0 : p - 16'd1; end
        else m_cnt = m_cnt + 16'd1;
      end else begin
        if (m_cnt == 0) begin m_dir = 1'b0; m_cnt = (p == 0) ? 16'd0 : 16'd1; end
        else m_cnt = m_cnt - 16'd1;
      end
    end
  endtask

  // Monitor: pop one expectation per cycle, compare before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        check(it.tag, "count", count, it.cnt);
        check(it.tag, "pwm_ref", pwm_ref, it.rf);
        check((it.tag == "R7") ? "R7" : "R6", "cmp_flag", cmp_flag, it.fl);
        check((it.tag == "R4") ? "R4" : "R9", "dir_now", dir_now, it.dr);
      end
    end
  end

  initial begin
    // R1: reset state with enable high and a nonzero compare
    enable = 1'b1; compare = 16'd4;
    #(PERIOD * 3 + 2);
    check("R1", "count", count, 0);
    check("R1", "cmp_flag", cmp_flag, 0);
    check("R1", "pwm_ref", pwm_ref, 0);
    @(negedge clk);
    enable = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: edge-aligned up-counting, then compare above the period
    for (int i = 0; i < 20; i++) drive(1, 2'b00, 0, 16'd8, 16'd4, 0, "R2");
    for (int i = 0; i < 10; i++) drive(1, 2'b00, 0, 16'd8, 16'd10, 1, "R2");
    // R3: edge-aligned down-counting, then compare above the period holds output high
    for (int i = 0; i < 20; i++) drive(1, 2'b00, 1, 16'd8, 16'd3, 0, "R3");
    for (int i = 0; i < 12; i++) drive(1, 2'b00, 1, 16'd8, 16'd9, 1, "R3");
    for (int i = 0; i < 12; i++) drive(1, 2'b00, 1, 16'd5, 16'd0, (i % 3) == 0, "R3");
    // R4: center-aligned sweep with dir_sel toggling (must be ignored)
    for (int i = 0; i < 3; i++) drive(1, 2'b00, 0, 16'd8, 16'd4, 1, "R4");
    for (int i = 0; i < 40; i++) drive(1, 2'b01, i[0], 16'd8, 16'd4, (i % 5) == 0, "R4");
    // R5: compare at period, above it, and zero
    for (int i = 0; i < 20; i++) drive(1, 2'b11, 0, 16'd8, 16'd8, 1, "R5");
    for (int i = 0; i < 20; i++) drive(1, 2'b10, 1, 16'd8, 16'd12, 1, "R5");
    for (int i = 0; i < 20; i++) drive(1, 2'b01, 0, 16'd8, 16'd0, 1, "R5");
    // R6: slope-selective flag in each center mode, clear every 4 cycles
    for (int i = 0; i < 36; i++) drive(1, 2'b01, 0, 16'd6, 16'd2, (i % 4) == 3, "R6");
    for (int i = 0; i < 36; i++) drive(1, 2'b10, 0, 16'd6, 16'd2, (i % 4) == 3, "R6");
    for (int i = 0; i < 36; i++) drive(1, 2'b11, 0, 16'd6, 16'd5, (i % 4) == 3, "R6");
    // R7: clear held high so matches collide with clears
    for (int i = 0; i < 24; i++) drive(1, 2'b11, 0, 16'd6, 16'd3, 1, "R7");
    for (int i = 0; i < 10; i++) drive(1, 2'b11, 0, 16'd6, 16'd3, 0, "R7");
    // R8: disabled with compare equal to the held count; clear first, flag must stay low
    drive(0, 2'b11, 0, 16'd6, m_cnt, 1, "R8");
    for (int i = 0; i < 10; i++) drive(0, 2'b11, 1, 16'd6, m_cnt, 0, "R8");
    for (int i = 0; i < 8; i++) drive(0, 2'b00, 0, 16'd6, 16'd0, 0, "R8");
    // R9: edge mode direction readback follows dir_sel immediately
    for (int i = 0; i < 12; i++) drive(1, 2'b00, i[1], 16'd7, 16'd2, 0, "R9");
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule